// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Front End

This block is the digital control side of a two-channel 10-bit digital-to-analog converter. A host writes 16-bit command words over a three-wire serial link. The wires are an active-low frame/load strobe, a serial clock and a data line. The block brings those wires into its own system clock domain. It assembles each frame and checks that the frame has the right length. It then decodes the control field and applies the command to a pair of registers per channel.

Each channel has a staging register that receives new codes and an output register that drives the converter. Commands can stage one channel or both channels. Output updates always copy both channels in the same cycle. A sleep command powers the analog side down and keeps every stored code. Staging loads are still accepted while the block is asleep. A single command then wakes the block and updates both outputs.

Top module: `dual_dac_ctrl`

## Requirements
- R1: A frame carries 16 bits. The first 4 bits received are the control code and the next 10 bits are the data code, each sent most significant bit first. The last 2 bits are ignored whatever their value.
- R2: A data bit is taken on each rising edge of `ser_clk` while `frame_n` is low. Edges of `ser_clk` while `frame_n` is high have no effect on stored state.
- R3: A command executes on the rising edge of `frame_n` only when exactly 16 rising clock edges were received in that frame. A frame with 15 or 17 edges leaves all registers and `asleep` unchanged.
- R4: After reset, both staging registers and both outputs are zero and `asleep` is 0.
- R5: Code 0001 stages the data into channel A, and code 0010 stages it into channel B. Outputs do not change and `asleep` keeps its value, including while asleep.
- R6: Code 1100 stages the same data into both channels without touching the outputs.
- R7: Code 1000 copies both staging registers into both outputs together and clears `asleep`.
- R8: Code 1001 stages the data into A and sets output A to the data. Output B is set to B's staging register and `asleep` is cleared. Code 1010 does the same with the channels swapped.
- R9: Code 1111 stages the data into both channels, sets both outputs to it and clears `asleep`.
- R10: Code 1110 sets `asleep`, ignores its data field and keeps all four registers unchanged.
- R11: Code 1101 clears `asleep` and leaves all registers unchanged.
- R12: Code 0000 and the unassigned codes (0011–0111, 1011) change no register and do not change `asleep`.
- R13: With `SYNC_STAGES` = 2, output changes appear at the 4th rising `clk` edge after `frame_n` rises, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on clear) |
| frame_n | input | 1 | Active-low frame strobe; its rising edge executes the command |
| ser_clk | input | 1 | Serial bit clock, sampled in the `clk` domain |
| ser_din | input | 1 | Serial data, most significant bit first |
| code_a | output | DATA_W | Output register of channel A |
| code_b | output | DATA_W | Output register of channel B |
| asleep | output | 1 | High while the analog side is powered down |

## Verification
The bench builds the block with its default parameters: 10-bit codes, two pad bits and a two-stage input synchronizer. With these values the frame is exactly 16 bits, which allows frames of 15 and 17 edges to be tested against the length check. The four-cycle command latency can then be pinned to an exact edge. The staging values are chosen to be asymmetric so that a swapped channel or a reversed bit order shows up at the outputs. Sleep is entered and left with loads in between, so that retained and freshly staged codes can be told apart.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP        = 4'b0000,
      OP_STAGE_A    = 4'b0001,
      OP_STAGE_B    = 4'b0010,
      OP_COMMIT     = 4'b1000,
      OP_STAGE_A_UP = 4'b1001,
      OP_STAGE_B_UP = 4'b1010,
      OP_STAGE_AB   = 4'b1100,
      OP_WAKE       = 4'b1101,
      OP_SLEEP      = 4'b1110,
      OP_BOTH_UP    = 4'b1111
   } dac_op_e;

   typedef struct packed {
      logic stage_a;
      logic stage_b;
      logic commit;
      logic go_sleep;
      logic go_wake;
   } dac_act_t;

endpackage

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
   parameter int            WIDTH   = 3,
   parameter int            STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
   parameter int CODE_W = 4,
   parameter int DATA_W = 10,
   parameter int PAD_W  = 2,
   localparam int WORD_W = CODE_W + DATA_W + PAD_W,
   localparam int CMD_W  = CODE_W + DATA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_s,
   input  logic             sclk_s,
   input  logic             din_s,
   output logic             cmd_valid,
   output logic [CMD_W-1:0] cmd_word
);

   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

   logic              sclk_d, frame_d;
   logic              bit_tick, frame_end;
   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  nbits;

   assign bit_tick  = sclk_s & ~sclk_d & ~frame_s;
   assign frame_end = frame_s & ~frame_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         frame_d <= 1'b1;
      end else begin
         sclk_d  <= sclk_s;
         frame_d <= frame_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         nbits <= '0;
      end else if (frame_s) begin
         nbits <= '0;
      end else if (bit_tick) begin
         shreg <= {shreg[WORD_W-2:0], din_s};
         if (nbits != CNT_SAT) nbits <= nbits + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         cmd_word  <= '0;
      end else begin
         cmd_valid <= frame_end && (nbits == CNT_FULL);
         if (frame_end) cmd_word <= shreg[WORD_W-1:PAD_W];
      end
   end

endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
   import dac_cmd_pkg::*;
(
   input  logic [OP_W-1:0] op,
   output dac_act_t        act
);

   always_comb begin
      act = '0;
      case (op)
         OP_STAGE_A:    act.stage_a = 1'b1;
         OP_STAGE_B:    act.stage_b = 1'b1;
         OP_STAGE_AB:   begin act.stage_a = 1'b1; act.stage_b = 1'b1; end
         OP_COMMIT:     begin act.commit = 1'b1; act.go_wake = 1'b1; end
         OP_STAGE_A_UP: begin act.stage_a = 1'b1; act.commit = 1'b1; act.go_wake = 1'b1; end
         OP_STAGE_B_UP: begin act.stage_b = 1'b1; act.commit = 1'b1; act.go_wake = 1'b1; end
         OP_BOTH_UP:    begin
            act.stage_a = 1'b1;
            act.stage_b = 1'b1;
            act.commit  = 1'b1;
            act.go_wake = 1'b1;
         end
         OP_WAKE:       act.go_wake  = 1'b1;
         OP_SLEEP:      act.go_sleep = 1'b1;
         default:       act = '0;
      endcase
   end

endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
   import dac_cmd_pkg::*;
#(
   parameter int DATA_W      = 10,
   parameter int PAD_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   output logic [DATA_W-1:0] code_a,
   output logic [DATA_W-1:0] code_b,
   output logic              asleep
);

   localparam int CMD_W = OP_W + DATA_W;
   localparam int N_CH  = 2;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (PAD_W < 1) begin : g_bad_pad
         $error("PAD_W must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [2:0]        raw_in, sync_out;
   logic              frame_s, sclk_s, din_s;
   logic              cmd_valid;
   logic [CMD_W-1:0]  cmd_word;
   logic [OP_W-1:0]   op;
   logic [DATA_W-1:0] payload;
   dac_act_t          act;
   logic [N_CH-1:0]   stage_sel;
   logic [DATA_W-1:0] in_a, in_b;

   assign raw_in = {frame_n, ser_clk, ser_din};

   dac_in_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign {frame_s, sclk_s, din_s} = sync_out;

   dac_frame_rx #(
      .CODE_W (OP_W),
      .DATA_W (DATA_W),
      .PAD_W  (PAD_W)
   ) i_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_s   (frame_s),
      .sclk_s    (sclk_s),
      .din_s     (din_s),
      .cmd_valid (cmd_valid),
      .cmd_word  (cmd_word)
   );

   assign op      = cmd_word[CMD_W-1 -: OP_W];
   assign payload = cmd_word[DATA_W-1:0];

   dac_cmd_decode i_dec (
      .op  (op),
      .act (act)
   );

   assign stage_sel = {act.stage_b, act.stage_a};

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      logic [DATA_W-1:0] stage_r, out_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_r <= '0;
            out_r   <= '0;
         end else if (cmd_valid) begin
            if (stage_sel[ch]) stage_r <= payload;
            if (act.commit) out_r <= stage_sel[ch] ? payload : stage_r;
         end
      end
   end

   assign in_a   = g_ch[0].stage_r;
   assign in_b   = g_ch[1].stage_r;
   assign code_a = g_ch[0].out_r;
   assign code_b = g_ch[1].out_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asleep <= 1'b0;
      end else if (cmd_valid) begin
         if (act.go_sleep)     asleep <= 1'b1;
         else if (act.go_wake) asleep <= 1'b0;
      end
   end

endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk #(
   parameter int DATA_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [DATA_W+3:0] cmd_word,
   input logic [DATA_W-1:0] in_a,
   input logic [DATA_W-1:0] in_b,
   input logic [DATA_W-1:0] code_a,
   input logic [DATA_W-1:0] code_b,
   input logic              asleep
);

   logic [3:0]        op;
   logic [DATA_W-1:0] dat;
   assign op  = cmd_word[DATA_W+3 -: 4];
   assign dat = cmd_word[DATA_W-1:0];

   // R3: without an accepted frame nothing moves
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> ($stable(code_a) && $stable(code_b) && $stable(in_a)
                      && $stable(in_b) && $stable(asleep)));

   // R5: staging channel A leaves outputs and sleep state alone
   p_stage_a_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == 4'b0001) |=> (in_a == $past(dat) && $stable(in_b)
         && $stable(code_a) && $stable(code_b) && $stable(asleep)));

   // R7: commit copies both staged codes and wakes
   p_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == 4'b1000) |=> (code_a == $past(in_a)
         && code_b == $past(in_b) && !asleep));

   // R9: broadcast load lands on both outputs
   p_both_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == 4'b1111) |=> (code_a == $past(dat)
         && code_b == $past(dat) && !asleep));

   // R10: sleep retains every register
   p_sleep_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == 4'b1110) |=> (asleep && $stable(code_a)
         && $stable(code_b) && $stable(in_a) && $stable(in_b)));

   // R11: wake without update
   p_wake_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && op == 4'b1101) |=> (!asleep && $stable(code_a)
         && $stable(code_b)));

endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_word  (cmd_word),
   .in_a      (in_a),
   .in_b      (in_b),
   .code_a    (code_a),
   .code_b    (code_b),
   .asleep    (asleep)
);

// File: tb/test_dual_dac_ctrl.sv
`timescale 1ns/1ps
module test_dual_dac_ctrl;

   localparam int DW   = 10;
   localparam int HALF = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_n = 1'b1;
   logic          ser_clk = 1'b0;
   logic          ser_din = 1'b0;
   logic [DW-1:0] code_a, code_b;
   logic          asleep;

   int total = 0;
   int bad   = 0;
   bit settled = 1'b0;
   bit finished = 1'b0;

   // behavioural model state
   int m_in_a = 0, m_in_b = 0, m_out_a = 0, m_out_b = 0, m_sleep = 0;

   always #10 clk = ~clk;

   dual_dac_ctrl i_dual_dac_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_n (frame_n),
      .ser_clk (ser_clk),
      .ser_din (ser_din),
      .code_a  (code_a),
      .code_b  (code_b),
      .asleep  (asleep)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic check_out(string req, int ea, int eb, int es);
      check({req, " code_a"}, int'(code_a), ea);
      check({req, " code_b"}, int'(code_b), eb);
      check({req, " asleep"}, int'(asleep), es);
   endtask

   function automatic void model_apply(int op, int d);
      case (op)
         1:  m_in_a = d;
         2:  m_in_b = d;
         12: begin m_in_a = d; m_in_b = d; end
         8:  begin m_out_a = m_in_a; m_out_b = m_in_b; m_sleep = 0; end
         9:  begin m_in_a = d; m_out_a = d; m_out_b = m_in_b; m_sleep = 0; end
         10: begin m_in_b = d; m_out_b = d; m_out_a = m_in_a; m_sleep = 0; end
         15: begin m_in_a = d; m_in_b = d; m_out_a = d; m_out_b = d; m_sleep = 0; end
         13: m_sleep = 0;
         14: m_sleep = 1;
         default: ;
      endcase
   endfunction

   // per-clock comparison against the model (R4 register state at the ports)
   always @(negedge clk) begin
      if (settled && !finished) begin
         check("R4 model code_a", int'(code_a), m_out_a);
         check("R4 model code_b", int'(code_b), m_out_b);
         check("R4 model asleep", int'(asleep), m_sleep);
      end
   end

   task automatic send_frame(int op, int d, int pad, int nbits);
      logic [15:0] w;
      w = {op[3:0], d[9:0], pad[1:0]};
      @(negedge clk);
      frame_n = 1'b0;
      ser_clk = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         ser_din = (i < 16) ? w[15-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b1;
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      settled = 1'b0;
      frame_n = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      if (nbits == 16) model_apply(op, d);
      settled = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      settled = 1'b1;
      // R4 reset state
      check_out("R4 reset", 0, 0, 0);

      // R5 staging only, R1 pad bits ignored
      send_frame(1, 'h2A5, 3, 16);
      check_out("R5 stage A", 0, 0, 0);
      send_frame(2, 'h15A, 0, 16);
      check_out("R5 stage B", 0, 0, 0);

      // R7 commit, with R13 latency pinned
      begin
         send_frame(8, 'h000, 0, 0);
      end
      send_frame(8, 'h3C3, 2, 16);
      check_out("R7 commit R1 order", 'h2A5, 'h15A, 0);

      // R13 latency: stage then commit with manual timing
      send_frame(1, 'h0C0, 0, 16);
      @(negedge clk);
      frame_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < 16; i++) begin
         ser_din = (i == 0);
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b1;
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      settled = 1'b0;
      frame_n = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R13 before 4th edge", int'(code_a), 'h2A5);
      @(posedge clk);
      @(negedge clk);
      check("R13 at 4th edge", int'(code_a), 'h0C0);
      model_apply(8, 0);
      settled = 1'b1;

      // R10 sleep keeps values, data ignored
      send_frame(14, 'h3FF, 0, 16);
      check_out("R10 sleep", 'h0C0, 'h15A, 1);
      // R5 staging while asleep
      send_frame(1, 'h001, 0, 16);
      check_out("R5 stage asleep", 'h0C0, 'h15A, 1);
      // R11 wake without update
      send_frame(13, 'h2AA, 0, 16);
      check_out("R11 wake", 'h0C0, 'h15A, 0);

      // R8 load-and-update each channel
      send_frame(9, 'h3FF, 0, 16);
      check_out("R8 A+update", 'h3FF, 'h15A, 0);
      send_frame(10, 'h000, 0, 16);
      check_out("R8 B+update", 'h3FF, 'h000, 0);

      // R6 stage both, then commit
      send_frame(12, 'h155, 0, 16);
      check_out("R6 stage both", 'h3FF, 'h000, 0);
      send_frame(8, 0, 0, 16);
      check_out("R6 commit both", 'h155, 'h155, 0);

      // R9 broadcast from sleep
      send_frame(14, 0, 0, 16);
      send_frame(15, 'h0F0, 0, 16);
      check_out("R9 broadcast", 'h0F0, 'h0F0, 0);

      // R3 wrong frame lengths
      send_frame(14, 'h3C3, 0, 15);
      check_out("R3 short frame", 'h0F0, 'h0F0, 0);
      send_frame(15, 'h3C3, 0, 17);
      check_out("R3 long frame", 'h0F0, 'h0F0, 0);

      // R12 no-op and unassigned codes, then commit exposes staging
      send_frame(0, 'h3AA, 0, 16);
      send_frame(3, 'h3AA, 0, 16);
      send_frame(7, 'h3AA, 0, 16);
      send_frame(11, 'h3AA, 0, 16);
      check_out("R12 nop outputs", 'h0F0, 'h0F0, 0);
      send_frame(8, 0, 0, 16);
      check_out("R12 nop staging", 'h0F0, 'h0F0, 0);

      // R2 clock edges while frame high
      @(negedge clk);
      ser_din = 1'b1;
      for (int i = 0; i < 8; i++) begin
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b1;
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b0;
      end
      repeat (6) @(negedge clk);
      check_out("R2 idle clocks", 'h0F0, 'h0F0, 0);
      send_frame(2, 'h0AB, 0, 16);
      send_frame(8, 0, 0, 16);
      check_out("R2 frame after idle", 'h0F0, 'h0AB, 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule